// File: doc/BRIEF.md
# Indexed Palette RAM Port

This block gives a processor byte-wide access to a colour lookup table of 256 entries, each holding a red, a green and a blue component of six bits. Four small registers make up the processor side. Two of them load separate addresses for writing and for reading. A third carries the colour data itself. The fourth is a mask applied to pixel indices. The table is loaded one component at a time. A small counter inside the block picks red, then green, then blue. After the third component the address steps to the next entry and wraps at the end of the table. Reading back works the same way through its own address and its own component counter.

A second, independent port serves the display side. Each cycle it takes a pixel index, ANDs it with the mask register, and returns the stored colour triple one clock later. Processor accesses never stall this port. Converting the triple to an analogue level, and any gamma computation, happen elsewhere.

A processor access is one cycle with `cpuSel` high. `cpuWrite` chooses a write or a read. `cpuAddr` picks the register: 0 is the write index, 1 is colour data, 2 is the pixel mask and 3 is the read index. Read data appears on `cpuRdata` in the cycle after the access and holds until the next read.

Top module: `palette_port`

## Requirements
- R1: While reset is low and after it is released, `cpuRdata` and all three pixel outputs are 0, both addresses and both component counters are 0, the mask is 0xFF and every table entry is 0.
- R2: A write to register 0 loads the write address from `cpuWdata` and returns the write component counter to red. A partly written triple is abandoned.
- R3: Writes to register 1 store `cpuWdata[5:0]` into red, then green, then blue of the entry at the write address. The address increments after the blue write.
- R4: The write address wraps from 255 to 0. After a full pass over 256 entries starting at 0, register 0 reads back 0.
- R5: A write to register 3 loads the read address and returns the read component counter to red. Reads of register 1 return red, green, then blue, then advance the read address, which wraps from 255 to 0.
- R6: Only six bits per component are kept. A read of register 1 returns the component on bits 5:0 with bits 7:6 as 0.
- R7: The pixel index is ANDed with the mask (register 2) before the table lookup. A mask of 0xFF passes the index unchanged.
- R8: Reads of registers 0, 2 and 3 return the write address, the mask and the read address respectively. They change no address, counter or table state.
- R9: The pixel outputs present the table contents at the masked index sampled on the previous clock edge, whatever the processor does. A data write in that same cycle shows up one cycle later.
- R10: `cpuRdata` changes only on the clock edge that ends a read access, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuSel | input | 1 | Processor access in this cycle |
| cpuWrite | input | 1 | 1 = write access, 0 = read access |
| cpuAddr | input | 2 | Register select: 0 write index, 1 data, 2 mask, 3 read index |
| cpuWdata | input | 8 | Write data |
| cpuRdata | output | 8 | Read data, valid the cycle after a read |
| pixIdx | input | 8 | Pixel index from the display pipeline |
| pixRed | output | 6 | Red component of the looked-up entry |
| pixGreen | output | 6 | Green component of the looked-up entry |
| pixBlue | output | 6 | Blue component of the looked-up entry |

## Verification
The bench targets several corner cases:
- Address wrap after the 256th triple. A design that fails to wrap leaves register 0 reading nonzero.
- Reloading the write index partway through a triple. If the component counter is not reset, the next byte lands in green instead of red.
- A read-address wrap across entry 255, and index-register reads placed between data writes. If such reads disturb state, later data lands in the wrong entry or component.
- Masked pixel lookups, and a pixel read of an entry written in the same cycle. Mistakes here show as wrong colours or a lookup that is early by one cycle.

A long random mix of all accesses is compared on every clock against a behavioural model.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int IDX_W    = 8;
  localparam int COMP_W   = 6;
  localparam int BUS_W    = 8;
  localparam int NUM_COMP = 3;
  localparam int DEPTH    = 1 << IDX_W;
  localparam int CMP_W    = $clog2(NUM_COMP);
  localparam logic [CMP_W-1:0] LAST_COMP = CMP_W'(NUM_COMP - 1);

  typedef enum logic [1:0] {
    REG_WIDX = 2'd0,
    REG_DATA = 2'd1,
    REG_MASK = 2'd2,
    REG_RIDX = 2'd3
  } palReg_e;

  typedef struct packed {
    logic             tableWr;
    logic             dataRd;
    logic             regRd;
    logic [IDX_W-1:0] wrAddr;
    logic [CMP_W-1:0] wrComp;
    logic [IDX_W-1:0] rdAddr;
    logic [CMP_W-1:0] rdComp;
  } palStrobe_t;
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuSel,
  input  logic             cpuWrite,
  input  logic [1:0]       cpuAddr,
  input  logic [BUS_W-1:0] cpuWdata,
  output palStrobe_t       stb,
  output logic [BUS_W-1:0] regValue,
  output logic [IDX_W-1:0] pixMask
);
  logic [IDX_W-1:0] wrAddrQ, rdAddrQ, maskQ;
  logic [CMP_W-1:0] wrCompQ, rdCompQ;
  palReg_e          regSel;
  logic             accWr, accRd;

  assign regSel = palReg_e'(cpuAddr);
  assign accWr  = cpuSel && cpuWrite;
  assign accRd  = cpuSel && !cpuWrite;

  // advance a component counter, wrapping back to red after blue
  function automatic logic [CMP_W-1:0] stepComp(input logic [CMP_W-1:0] c);
    return (c == LAST_COMP) ? '0 : c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddrQ <= '0;
      wrCompQ <= '0;
      rdAddrQ <= '0;
      rdCompQ <= '0;
      maskQ   <= '1;
    end else if (accWr) begin
      unique case (regSel)
        REG_WIDX: begin
          wrAddrQ <= cpuWdata[IDX_W-1:0];
          wrCompQ <= '0;
        end
        REG_DATA: begin
          wrCompQ <= stepComp(wrCompQ);
          if (wrCompQ == LAST_COMP) wrAddrQ <= wrAddrQ + 1'b1;
        end
        REG_MASK: maskQ <= cpuWdata[IDX_W-1:0];
        REG_RIDX: begin
          rdAddrQ <= cpuWdata[IDX_W-1:0];
          rdCompQ <= '0;
        end
        default: ;
      endcase
    end else if (accRd && regSel == REG_DATA) begin
      rdCompQ <= stepComp(rdCompQ);
      if (rdCompQ == LAST_COMP) rdAddrQ <= rdAddrQ + 1'b1;
    end
  end

  always_comb begin
    regValue = '0;
    unique case (regSel)
      REG_WIDX: regValue = BUS_W'(wrAddrQ);
      REG_MASK: regValue = BUS_W'(maskQ);
      REG_RIDX: regValue = BUS_W'(rdAddrQ);
      default:  regValue = '0;
    endcase
  end

  assign stb.tableWr = accWr && (regSel == REG_DATA);
  assign stb.dataRd  = accRd && (regSel == REG_DATA);
  assign stb.regRd   = accRd && (regSel != REG_DATA);
  assign stb.wrAddr  = wrAddrQ;
  assign stb.wrComp  = wrCompQ;
  assign stb.rdAddr  = rdAddrQ;
  assign stb.rdComp  = rdCompQ;
  assign pixMask     = maskQ;
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
(
  input  logic                             clk,
  input  logic                             rstN,
  input  palStrobe_t                       stb,
  input  logic [BUS_W-1:0]                 cpuWdata,
  input  logic [BUS_W-1:0]                 regValue,
  input  logic [IDX_W-1:0]                 pixMask,
  input  logic [IDX_W-1:0]                 pixIdx,
  output logic [BUS_W-1:0]                 cpuRdata,
  output logic [NUM_COMP-1:0][COMP_W-1:0]  pixTriple
);
  logic [IDX_W-1:0]                pixAddr;
  logic [NUM_COMP-1:0][COMP_W-1:0] compRd;
  logic [COMP_W-1:0]               rdPick;

  assign pixAddr = pixIdx & pixMask;

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
    logic [COMP_W-1:0] tbl [DEPTH];
    logic [COMP_W-1:0] pixQ;
    logic              wrHit;

    assign wrHit = stb.tableWr && (stb.wrComp == CMP_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
        pixQ <= '0;
      end else begin
        if (wrHit) tbl[stb.wrAddr] <= cpuWdata[COMP_W-1:0];
        pixQ <= tbl[pixAddr];
      end
    end

    assign compRd[c]    = tbl[stb.rdAddr];
    assign pixTriple[c] = pixQ;
  end

  always_comb begin
    rdPick = '0;
    for (int c = 0; c < NUM_COMP; c++)
      if (stb.rdComp == CMP_W'(c)) rdPick = compRd[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           cpuRdata <= '0;
    else if (stb.dataRd) cpuRdata <= BUS_W'(rdPick);
    else if (stb.regRd)  cpuRdata <= regValue;
  end
endmodule

// File: rtl/palette_port.sv
module palette_port
  import palette_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuSel,
  input  logic              cpuWrite,
  input  logic [1:0]        cpuAddr,
  input  logic [BUS_W-1:0]  cpuWdata,
  output logic [BUS_W-1:0]  cpuRdata,
  input  logic [IDX_W-1:0]  pixIdx,
  output logic [COMP_W-1:0] pixRed,
  output logic [COMP_W-1:0] pixGreen,
  output logic [COMP_W-1:0] pixBlue
);
  palStrobe_t                      stb;
  logic [BUS_W-1:0]                regValue;
  logic [IDX_W-1:0]                pixMask;
  logic [NUM_COMP-1:0][COMP_W-1:0] pixTriple;

  palette_ctrl ctrlU (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .stb(stb),
    .regValue(regValue), .pixMask(pixMask)
  );

  palette_store storeU (
    .clk(clk), .rstN(rstN), .stb(stb), .cpuWdata(cpuWdata),
    .regValue(regValue), .pixMask(pixMask), .pixIdx(pixIdx),
    .cpuRdata(cpuRdata), .pixTriple(pixTriple)
  );

  assign pixRed   = pixTriple[0];
  assign pixGreen = pixTriple[1];
  assign pixBlue  = pixTriple[2];
endmodule

// File: rtl/palette_port_chk.sv
module palette_port_chk
  import palette_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cpuSel,
  input logic             cpuWrite,
  input logic [1:0]       cpuAddr,
  input logic [BUS_W-1:0] cpuWdata,
  input logic [BUS_W-1:0] cpuRdata,
  input palStrobe_t       stb
);
  // R10
  hold_rdata_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuSel |=> $stable(cpuRdata));

  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && !cpuWrite && cpuAddr == 2'd1) |=> (cpuRdata[7:6] == 2'b00));

  // R2
  wr_index_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && cpuWrite && cpuAddr == 2'd0)
      |=> (stb.wrAddr == $past(cpuWdata[IDX_W-1:0]) && stb.wrComp == '0));

  // R5
  rd_index_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && cpuWrite && cpuAddr == 2'd3)
      |=> (stb.rdAddr == $past(cpuWdata[IDX_W-1:0]) && stb.rdComp == '0));

  // R3
  comp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && cpuWrite && cpuAddr == 2'd1 && stb.wrComp != LAST_COMP)
      |=> (stb.wrComp == $past(stb.wrComp) + 1'b1 && $stable(stb.wrAddr)));

  // R4
  wr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && cpuWrite && cpuAddr == 2'd1 && stb.wrComp == LAST_COMP && stb.wrAddr == '1)
      |=> (stb.wrAddr == '0 && stb.wrComp == '0));

  // R8
  wr_state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuSel && !(cpuWrite && (cpuAddr == 2'd0 || cpuAddr == 2'd1)))
      |=> ($stable(stb.wrAddr) && $stable(stb.wrComp)));
endmodule

bind palette_port palette_port_chk chkU (
  .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWrite(cpuWrite),
  .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata), .stb(stb)
);

// File: tb/palette_port_test.sv
`timescale 1ns/1ps
module palette_port_test;
  logic       clk = 0;
  logic       rstN = 0;
  logic       cpuSel = 0, cpuWrite = 0;
  logic [1:0] cpuAddr = 0;
  logic [7:0] cpuWdata = 0;
  logic [7:0] cpuRdata;
  logic [7:0] pixIdx = 0;
  logic [5:0] pixRed, pixGreen, pixBlue;

  int compared = 0, mismatched = 0;
  string curTag = "R10";
  bit finished = 0;

  always #10 clk = ~clk;

  palette_port uut (
    .clk(clk), .rstN(rstN), .cpuSel(cpuSel), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .pixIdx(pixIdx), .pixRed(pixRed), .pixGreen(pixGreen), .pixBlue(pixBlue)
  );

  // behavioural reference
  int mem [3][256];
  int mW, mWC, mR, mRC, mMask, eRd;
  int ePix [3];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < 3; c++) for (int i = 0; i < 256; i++) mem[c][i] = 0;
      mW = 0; mWC = 0; mR = 0; mRC = 0; mMask = 255; eRd = 0;
      for (int c = 0; c < 3; c++) ePix[c] = 0;
    end else begin
      for (int c = 0; c < 3; c++) ePix[c] = mem[c][pixIdx & mMask];
      if (cpuSel && cpuWrite) begin
        case (cpuAddr)
          0: begin mW = cpuWdata; mWC = 0; end
          1: begin
            mem[mWC][mW] = cpuWdata & 63;
            if (mWC == 2) begin mWC = 0; mW = (mW + 1) % 256; end else mWC++;
          end
          2: mMask = cpuWdata;
          default: begin mR = cpuWdata; mRC = 0; end
        endcase
      end else if (cpuSel) begin
        case (cpuAddr)
          0: eRd = mW;
          1: begin
            eRd = mem[mRC][mR];
            if (mRC == 2) begin mRC = 0; mR = (mR + 1) % 256; end else mRC++;
          end
          2: eRd = mMask;
          default: eRd = mR;
        endcase
      end
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (!finished) begin
    chk(curTag, "cpuRdata model", cpuRdata, eRd);
    chk("R9", "pixRed model", pixRed, ePix[0]);
    chk("R9", "pixGreen model", pixGreen, ePix[1]);
    chk("R9", "pixBlue model", pixBlue, ePix[2]);
  end

  task automatic acc(bit w, int a, int d);
    cpuSel = 1; cpuWrite = w; cpuAddr = 2'(a); cpuWdata = 8'(d);
    @(posedge clk); #2;
    cpuSel = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic summary;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    chk("R1", "rdata in reset", cpuRdata, 0);
    rstN = 1;
    idle(1);
    // R1 reset state
    chk("R1", "pixRed after reset", pixRed, 0);
    curTag = "R1";
    acc(0, 2, 0); chk("R1", "mask reset", cpuRdata, 8'hFF);
    acc(0, 0, 0); chk("R1", "write index reset", cpuRdata, 0);
    acc(0, 1, 0); chk("R1", "table reset", cpuRdata, 0);

    // R3 R4 full load with upper bits set
    curTag = "R3";
    acc(1, 0, 0);
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) acc(1, 1, ((i * 3 + c) & 8'hFF) ^ 8'hC0);
    acc(0, 0, 0); chk("R4", "write index after full pass", cpuRdata, 0);

    // R5 R6 readback
    curTag = "R5";
    acc(1, 3, 5);
    for (int c = 0; c < 3; c++) begin
      acc(0, 1, 0); chk("R6", "entry5 comp", cpuRdata, (15 + c) & 63);
    end
    acc(0, 3, 0); chk("R5", "read index advanced", cpuRdata, 6);
    acc(1, 3, 255);
    for (int k = 0; k < 6; k++) begin
      acc(0, 1, 0);
      chk("R5", "read wrap", cpuRdata, (k < 3) ? ((765 + k) & 63) : (k - 3));
    end
    acc(0, 3, 0); chk("R5", "read index wrapped", cpuRdata, 1);
    acc(1, 3, 7); acc(0, 1, 0);
    acc(1, 3, 7); acc(0, 1, 0); chk("R5", "counter reset to red", cpuRdata, 21 & 63);

    // R2 reload mid-triple
    curTag = "R2";
    acc(1, 0, 10); acc(1, 1, 8'h11);
    acc(1, 0, 10); acc(1, 1, 8'h21); acc(1, 1, 8'h22); acc(1, 1, 8'h23);
    acc(1, 3, 10);
    for (int c = 0; c < 3; c++) begin
      acc(0, 1, 0); chk("R2", "entry10 after reload", cpuRdata, 8'h21 + c);
    end

    // R8 register reads between data writes
    curTag = "R8";
    acc(1, 0, 20); acc(1, 1, 8'h31);
    acc(0, 0, 0); chk("R8", "write index read", cpuRdata, 20);
    acc(0, 2, 0); chk("R8", "mask read", cpuRdata, 8'hFF);
    acc(0, 3, 0); chk("R8", "read index read", cpuRdata, 11);
    acc(1, 1, 8'h32); acc(1, 1, 8'h33);
    acc(0, 0, 0); chk("R3", "advance after blue", cpuRdata, 21);
    idle(3); chk("R10", "rdata held", cpuRdata, 21);
    acc(1, 3, 20);
    for (int c = 0; c < 3; c++) begin
      acc(0, 1, 0); chk("R8", "entry20 intact", cpuRdata, 8'h31 + c);
    end

    // R9 R7 pixel side
    curTag = "R10";
    pixIdx = 10; idle(1);
    chk("R9", "pix red entry10", pixRed, 8'h21);
    chk("R9", "pix blue entry10", pixBlue, 8'h23);
    acc(1, 2, 8'h0F);
    pixIdx = 8'h1A; idle(1);
    chk("R7", "masked green", pixGreen, 8'h22);
    acc(1, 2, 8'hFF);
    pixIdx = 8'h1A; idle(1);
    chk("R7", "unmasked red", pixRed, (26 * 3) & 63);
    pixIdx = 10;
    acc(1, 0, 10); acc(1, 1, 8'h3F);
    chk("R9", "same-cycle write shows old", pixRed, 8'h21);
    idle(1);
    chk("R9", "write visible next cycle", pixRed, 8'h3F);

    // random mix compared on every clock
    curTag = "R10";
    for (int n = 0; n < 4000; n++) begin
      pixIdx = 8'($urandom);
      cpuSel = 1'($urandom); cpuWrite = 1'($urandom);
      cpuAddr = 2'($urandom); cpuWdata = 8'($urandom);
      if (cpuWrite && cpuAddr == 2 && ($urandom % 4 != 0)) cpuWdata = 8'hFF;
      @(posedge clk); #2;
    end
    cpuSel = 0;
    idle(2);
    summary();
  end
endmodule